// File: doc/BRIEF.md
# Road Hit Selector With Layer Majority

This block takes the silicon clusters found inside one track road and keeps, on each of four detector layers, the single cluster nearest the road centre. Each cluster arrives as a signed offset from the centre, tagged with its layer and a cluster address. When the road closes, the block decides whether enough layers hold a hit for a track fit to be worth running. It then emits either a candidate record or a reject flag.

A road opens with a start pulse that carries the two fiber-tracker hits defining it. Clusters then stream in at up to one per cycle, and an end pulse closes the road. The block keeps one best-so-far register per layer and needs no other storage. The candidate record holds both fiber hits, the chosen offset and address for each layer, a layer-present mask and the number of layers that hold a hit. A downstream fitter consumes this record.

Top module: `road_hit_selector`

## Requirements
- R1: While reset is held, and in the first cycle after reset, `cand_valid_o` and `reject_o` are low and `cand_mask_o`, `cand_count_o`, `cand_fib0_o` and `cand_fib1_o` are zero.
- R2: The block ignores a cluster whose offset magnitude exceeds `HALF`, the half-width of the road in offset units. The bound is inclusive, so with the default value offsets of -500 and +500 are kept and -501 and +501 are dropped.
- R3: On each layer the block selects, among the in-window clusters of the road, the one with the smallest absolute offset.
- R4: When two in-window clusters on one layer have equal absolute offsets, the one with the lower `cl_addr_i` is selected, whatever their order of arrival. For equal addresses the earlier cluster is kept.
- R5: If at least `MIN_LAY` layers (default 3) hold a selection when the road ends, `cand_valid_o` pulses for exactly the one cycle after the end.
  - Bit i of `cand_mask_o` marks layer i.
  - `cand_count_o` is the population count of the mask.
  - Layer i's offset sits in `cand_pos_o[i*POS_W +: POS_W]` and its address in `cand_addr_o[i*AW +: AW]`.
  - Both fields are zero for an empty layer.
- R6: If fewer than `MIN_LAY` layers hold a selection, `reject_o` pulses for the one cycle after the end, and `cand_valid_o` stays low. All candidate fields keep the values of the last accepted road.
- R7: The candidate's `cand_fib0_o` and `cand_fib1_o` equal the fiber hits given with that road's start pulse.
- R8: A start pulse discards any state left from an earlier road. A cluster presented in the start cycle or in the end cycle belongs to the road. Start and end may share one cycle.
- R9: `cand_valid_o` and `reject_o` are never both high, and neither rises in a cycle that does not follow an end pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| road_start_i | input | 1 | Opens a road and captures the fiber hits |
| fib0_i | input | FIB_W | First fiber-tracker hit of the road |
| fib1_i | input | FIB_W | Second fiber-tracker hit of the road |
| cl_valid_i | input | 1 | A cluster is presented this cycle |
| cl_layer_i | input | LW | Layer number of the cluster |
| cl_pos_i | input | POS_W | Signed offset of the cluster from the road centre |
| cl_addr_i | input | AW | Cluster address, used to break ties |
| road_end_i | input | 1 | Closes the road; a cluster in this cycle is included |
| cand_valid_o | output | 1 | One-cycle pulse for an accepted road |
| reject_o | output | 1 | One-cycle pulse for a rejected road |
| cand_fib0_o | output | FIB_W | First fiber hit of the candidate |
| cand_fib1_o | output | FIB_W | Second fiber hit of the candidate |
| cand_pos_o | output | NLAY*POS_W | Selected offset for each layer |
| cand_addr_o | output | NLAY*AW | Selected cluster address for each layer |
| cand_mask_o | output | NLAY | Layer-present mask |
| cand_count_o | output | CW | Number of layers holding a hit |

## Verification
The tie rule is the hardest behaviour to reach from the ports. It needs two in-window clusters on the same layer at the same distance. They may sit on opposite sides of the centre, and they must arrive with their addresses both ascending and descending. Random offsets almost never produce such a pair. The stimulus therefore includes directed roads that mirror an offset and swap the arrival order. The random roads also draw offsets from a narrow band of a few values, so exact ties occur often. Further directed roads place clusters exactly on and one past both window edges. Others put start and end in one cycle, to show that no state leaks from the previous road.

// File: rtl/road_hit_selector.sv
module road_hit_selector #(
  parameter int NLAY    = 4,
  parameter int POS_W   = 12,
  parameter int AW      = 8,
  parameter int FIB_W   = 16,
  parameter int HALF    = 500,
  parameter int MIN_LAY = 3,
  localparam int LW = (NLAY > 1) ? $clog2(NLAY) : 1,
  localparam int CW = $clog2(NLAY + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    road_start_i,
  input  logic [FIB_W-1:0]        fib0_i,
  input  logic [FIB_W-1:0]        fib1_i,
  input  logic                    cl_valid_i,
  input  logic [LW-1:0]           cl_layer_i,
  input  logic signed [POS_W-1:0] cl_pos_i,
  input  logic [AW-1:0]           cl_addr_i,
  input  logic                    road_end_i,
  output logic                    cand_valid_o,
  output logic                    reject_o,
  output logic [FIB_W-1:0]        cand_fib0_o,
  output logic [FIB_W-1:0]        cand_fib1_o,
  output logic [NLAY*POS_W-1:0]   cand_pos_o,
  output logic [NLAY*AW-1:0]      cand_addr_o,
  output logic [NLAY-1:0]         cand_mask_o,
  output logic [CW-1:0]           cand_count_o
);

  logic [FIB_W-1:0] fib0_q, fib1_q;
  logic [NLAY-1:0]  have_q, have_b, have_n, take;
  logic [POS_W-1:0] pos_q  [NLAY];
  logic [POS_W:0]   dist_q [NLAY];
  logic [AW-1:0]    addr_q [NLAY];
  logic [NLAY*POS_W-1:0] pos_n;
  logic [NLAY*AW-1:0]    addr_n;
  logic [CW-1:0]    cnt_n;

  wire [POS_W:0] ext      = {cl_pos_i[POS_W-1], cl_pos_i};
  wire [POS_W:0] new_dist = ext[POS_W] ? (~ext + 1'b1) : ext;
  wire           in_win   = cl_valid_i && (new_dist <= (POS_W+1)'(HALF));
  wire           accept   = (int'(cnt_n) >= MIN_LAY);

  assign have_b = road_start_i ? '0 : have_q;
  assign have_n = have_b | take;

  for (genvar i = 0; i < NLAY; i++) begin : g_lay
    assign take[i] = in_win && (cl_layer_i == LW'(i)) &&
                     (!have_b[i] || (new_dist < dist_q[i]) ||
                      ((new_dist == dist_q[i]) && (cl_addr_i < addr_q[i])));
    assign pos_n[i*POS_W +: POS_W] = take[i] ? cl_pos_i  : (have_b[i] ? pos_q[i]  : '0);
    assign addr_n[i*AW +: AW]      = take[i] ? cl_addr_i : (have_b[i] ? addr_q[i] : '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pos_q[i]  <= '0;
        dist_q[i] <= '0;
        addr_q[i] <= '0;
      end else if (take[i]) begin
        pos_q[i]  <= cl_pos_i;
        dist_q[i] <= new_dist;
        addr_q[i] <= cl_addr_i;
      end
    end

    assert_in_road_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_valid_o && cand_mask_o[i]) |->
        ((int'($signed(cand_pos_o[i*POS_W +: POS_W])) <= HALF) &&
         (int'($signed(cand_pos_o[i*POS_W +: POS_W])) >= -HALF)));

    assert_empty_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_valid_o && !cand_mask_o[i]) |->
        (cand_pos_o[i*POS_W +: POS_W] == '0 && cand_addr_o[i*AW +: AW] == '0));
  end

  always_comb begin
    cnt_n = '0;
    for (int i = 0; i < NLAY; i++) cnt_n = cnt_n + CW'(have_n[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_q <= '0;
      fib0_q <= '0;
      fib1_q <= '0;
    end else begin
      have_q <= road_end_i ? '0 : have_n;
      if (road_start_i) begin
        fib0_q <= fib0_i;
        fib1_q <= fib1_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand_valid_o <= 1'b0;
      reject_o     <= 1'b0;
      cand_fib0_o  <= '0;
      cand_fib1_o  <= '0;
      cand_pos_o   <= '0;
      cand_addr_o  <= '0;
      cand_mask_o  <= '0;
      cand_count_o <= '0;
    end else begin
      cand_valid_o <= road_end_i && accept;
      reject_o     <= road_end_i && !accept;
      if (road_end_i && accept) begin
        cand_fib0_o  <= road_start_i ? fib0_i : fib0_q;
        cand_fib1_o  <= road_start_i ? fib1_i : fib1_q;
        cand_pos_o   <= pos_n;
        cand_addr_o  <= addr_n;
        cand_mask_o  <= have_n;
        cand_count_o <= cnt_n;
      end
    end
  end

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cand_valid_o && reject_o));

  assert_pulse_after_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    road_end_i |=> (cand_valid_o || reject_o));

  assert_quiet_otherwise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !road_end_i |=> !(cand_valid_o || reject_o));

  assert_count_matches_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid_o |-> ($countones(cand_mask_o) == int'(cand_count_o) &&
                      int'(cand_count_o) >= MIN_LAY));

  assert_reject_holds_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reject_o |-> ($stable(cand_mask_o) && $stable(cand_pos_o) && $stable(cand_fib0_o)));

endmodule

// File: tb/road_hit_selector_test.sv
module road_hit_selector_test;
  localparam int PERIOD = 10;
  localparam int NLAY = 4, POS_W = 12, AW = 8, FIB_W = 16, HALF = 500, MIN_LAY = 3;

  logic clk = 0, rst_n = 0;
  logic road_start_i = 0, cl_valid_i = 0, road_end_i = 0;
  logic [FIB_W-1:0] fib0_i = 0, fib1_i = 0;
  logic [1:0] cl_layer_i = 0;
  logic signed [POS_W-1:0] cl_pos_i = 0;
  logic [AW-1:0] cl_addr_i = 0;
  logic cand_valid_o, reject_o;
  logic [FIB_W-1:0] cand_fib0_o, cand_fib1_o;
  logic [NLAY*POS_W-1:0] cand_pos_o;
  logic [NLAY*AW-1:0] cand_addr_o;
  logic [NLAY-1:0] cand_mask_o;
  logic [2:0] cand_count_o;

  road_hit_selector uut (.*);

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int q_layer[64], q_pos[64], q_addr[64];
  int qn;
  int e_pos[NLAY], e_addr[NLAY], e_mask, e_cnt, e_fib0, e_fib1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic bit model_accept(input int fa, input int fb);
    int bp[NLAY], ba[NLAY];
    bit hv[NLAY];
    int cnt = 0;
    for (int l = 0; l < NLAY; l++) begin hv[l] = 0; bp[l] = 0; ba[l] = 0; end
    for (int k = 0; k < qn; k++) begin
      int l = q_layer[k];
      if (iabs(q_pos[k]) > HALF) continue;
      if (!hv[l] || iabs(q_pos[k]) < iabs(bp[l]) ||
          (iabs(q_pos[k]) == iabs(bp[l]) && q_addr[k] < ba[l])) begin
        hv[l] = 1; bp[l] = q_pos[k]; ba[l] = q_addr[k];
      end
    end
    for (int l = 0; l < NLAY; l++) cnt += hv[l];
    if (cnt >= MIN_LAY) begin
      e_mask = 0;
      for (int l = 0; l < NLAY; l++) begin
        e_mask |= hv[l] << l;
        e_pos[l] = bp[l];
        e_addr[l] = ba[l];
      end
      e_cnt = cnt; e_fib0 = fa; e_fib1 = fb;
    end
    return cnt >= MIN_LAY;
  endfunction

  task automatic add(input int l, input int p, input int a);
    q_layer[qn] = l; q_pos[qn] = p; q_addr[qn] = a; qn++;
  endtask

  task automatic run_road(input int fa, input int fb, input string req);
    bit acc;
    acc = model_accept(fa, fb);
    if (qn == 0) begin
      @(negedge clk);
      road_start_i = 1; road_end_i = 1; cl_valid_i = 0;
      fib0_i = FIB_W'(fa); fib1_i = FIB_W'(fb);
    end
    for (int k = 0; k < qn; k++) begin
      @(negedge clk);
      if (k > 0) chk(!cand_valid_o && !reject_o, "R9", "pulse mid-road", cand_valid_o, 0);
      road_start_i = (k == 0); road_end_i = (k == qn - 1);
      fib0_i = FIB_W'(fa); fib1_i = FIB_W'(fb);
      cl_valid_i = 1; cl_layer_i = 2'(q_layer[k]);
      cl_pos_i = POS_W'(q_pos[k]); cl_addr_i = AW'(q_addr[k]);
    end
    @(negedge clk);
    road_start_i = 0; road_end_i = 0; cl_valid_i = 0;
    chk(cand_valid_o == acc, acc ? "R5" : "R6", "cand_valid", cand_valid_o, acc);
    chk(reject_o == !acc, acc ? "R5" : "R6", "reject", reject_o, !acc);
    chk(int'(cand_mask_o) == e_mask, req, "mask", cand_mask_o, e_mask);
    chk(int'(cand_count_o) == e_cnt, "R5", "count", cand_count_o, e_cnt);
    chk(int'(cand_fib0_o) == e_fib0 && int'(cand_fib1_o) == e_fib1, "R7", "fib0", cand_fib0_o, e_fib0);
    for (int l = 0; l < NLAY; l++) begin
      int ap = int'($signed(cand_pos_o[l*POS_W +: POS_W]));
      int aa = int'(cand_addr_o[l*AW +: AW]);
      chk(ap == e_pos[l], req, $sformatf("pos layer %0d", l), ap, e_pos[l]);
      chk(aa == e_addr[l], req, $sformatf("addr layer %0d", l), aa, e_addr[l]);
    end
    @(negedge clk);
    chk(!cand_valid_o && !reject_o, "R9", "pulse width", cand_valid_o + reject_o, 0);
    qn = 0;
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    qn = 0; e_mask = 0; e_cnt = 0; e_fib0 = 0; e_fib1 = 0;
    for (int l = 0; l < NLAY; l++) begin e_pos[l] = 0; e_addr[l] = 0; end
    repeat (3) @(negedge clk);
    chk(!cand_valid_o && !reject_o && cand_mask_o == 0 && cand_count_o == 0, "R1", "reset outputs", cand_mask_o, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!cand_valid_o && !reject_o && cand_fib0_o == 0 && cand_fib1_o == 0, "R1", "after reset", cand_valid_o, 0);

    // R5 R7: all four layers
    add(0, 10, 1); add(1, -20, 2); add(2, 30, 3); add(3, -40, 4);
    run_road(16'h1234, 16'hBEEF, "R5");
    // R5: three layers
    add(0, 5, 7); add(2, 6, 8); add(3, 7, 9);
    run_road(11, 22, "R5");
    // R6: two layers rejected, fields unchanged
    add(0, 1, 1); add(1, 2, 2);
    run_road(33, 44, "R6");
    // R2: window edges
    add(0, 501, 1); add(0, -501, 2); add(1, 500, 3); add(2, -500, 4); add(3, 0, 5);
    run_road(1, 2, "R2");
    add(0, 501, 1); add(1, -501, 2); add(2, 499, 3); add(3, 0, 4);
    run_road(3, 4, "R2");
    // R3: nearest chosen
    add(0, 300, 1); add(0, -100, 2); add(0, 50, 3); add(0, 200, 4);
    add(1, -7, 5); add(1, 6, 6); add(2, 400, 9); add(3, -3, 1);
    run_road(5, 6, "R3");
    // R4: tie, lower address arrives second then first
    add(0, 20, 9); add(0, -20, 3); add(1, 0, 1); add(2, 0, 1); add(3, 0, 1);
    run_road(7, 8, "R4");
    add(0, -20, 3); add(0, 20, 9); add(1, 5, 4); add(1, -5, 4); add(2, 0, 1); add(3, 0, 1);
    run_road(7, 8, "R4");
    // R8: start and end in one cycle, single cluster -> reject, no leak from previous road
    add(0, 0, 1);
    run_road(9, 9, "R8");
    qn = 0;
    run_road(9, 9, "R8");
    // R8: three layers after a four-layer road
    add(0, 1, 1); add(1, 1, 1); add(2, 1, 1); add(3, 1, 1);
    run_road(12, 13, "R8");
    add(1, 2, 2); add(2, 3, 3); add(3, 4, 4);
    run_road(14, 15, "R8");

    // random roads with narrow offset bands for frequent ties
    for (int r = 0; r < 400; r++) begin
      int n = $urandom_range(1, 12);
      bit narrow = $urandom_range(0, 1);
      for (int k = 0; k < n; k++) begin
        int p = narrow ? ($urandom_range(0, 6) - 3) * 10 : $urandom_range(0, 1600) - 800;
        add($urandom_range(0, 3), p, $urandom_range(0, 15));
      end
      run_road($urandom_range(0, 65535), $urandom_range(0, 65535), "R3");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule